// File: doc/BRIEF.md
# Three-Mode General-Purpose Timer Bank

This block holds a small bank of general-purpose timers. Each timer owns one pin and one 32-bit counter, and that counter serves three operating modes. In waveform mode the timer drives the pin with a programmable pulse train. In capture mode the timer listens to the pin and records how long the pin stays asserted and how long one full cycle of the pin lasts. In watchdog mode the timer listens to the pin and signals when the edges stop arriving for too long.

Software programs each timer through a flat register space. Each timer has a 6-bit configuration register and three 32-bit registers: count, period and width. One shared register at address 0 starts and stops every timer on its own and holds the sticky event flags. Each timer has a dedicated interrupt line. The line is its event flag gated by that timer's interrupt-enable bit.

Top module: `gpt_timer_bank`

## Requirements
- R1: After reset every enable bit, event flag, configuration field, counter, period and width register reads zero, every `pinOe` bit is 0 and every `irq` bit is 0.
- R2: Configuration bits [1:0] select the mode: 0 off, 1 waveform, 2 capture, 3 watchdog. In waveform mode `pinOe` is 1. While the timer runs, the pin is active for the first `width` counts of each cycle of `period` counts, and the count steps 0,1,…,period-1 and then returns to 0.
- R3: In waveform mode, each return of the count to zero sets the timer's event flag.
- R4: Configuration bit 2 inverts the pin. In waveform mode the active level becomes low, and a stopped timer drives its inactive level, which is high when bit 2 is set and low otherwise. In the input modes, the falling level of the pin counts as asserted.
- R5: In capture mode, the first rising edge after start only arms the timer. After that, each falling edge loads the number of counted clocks at the asserted level into the width register. Each later rising edge loads the number of counted clocks since the previous rising edge into the period register and sets the event flag. The pin passes through a two-stage synchronizer before these edges are detected.
- R6: In watchdog mode, each rising edge of the pin restarts the count. When `period` counts pass with no edge, the event flag is set and the count restarts. An edge that arrives in the same cycle as an expiry wins, and no flag is set.
- R7: Configuration bit 4 set makes the counter advance only in cycles where `tick` is 1. Edge detection still runs on every clock.
- R8: Configuration bit 5 (run once) clears the timer's enable bit in the cycle after its first event.
- R9: `irq[t]` equals flag t AND configuration bit 3. Writing 1 to status bit 2N+t clears flag t, and an event in the same cycle wins over the clear.
- R10: Address 0 controls the timers. Writing 1 to bit t enables timer t. Writing 1 to bit N+t disables it, and a disable wins over an enable in the same write. Reading address 0 returns the enables in bits [N-1:0] and the flags in bits [3N-1:2N]. Enabling a stopped timer clears its count, and writes to one timer's bits leave the other timers unchanged.
- R11: A disabled timer holds its count and raises no events.
- R12: Timer t's registers sit at address 4(t+1)+k, with k = 0 configuration, 1 count, 2 period and 3 width. All of them can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe used when configuration bit 4 is set |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Read data for `regAddr`, combinational |
| pinIn | input | NUM_TIMERS | Pin input levels, asynchronous |
| pinOut | output | NUM_TIMERS | Pin output levels |
| pinOe | output | NUM_TIMERS | Pin output enables |
| irq | output | NUM_TIMERS | Per-timer interrupt lines |

## Verification
The embedded assertions check, on every cycle, the rules that hold from one cycle to the next. A run-once event must drop the enable bit. A stopped timer must never raise an event. A flag may only rise after an event. A captured period must equal the count at the capture edge, and an increment must step the count by exactly one. The bench scenarios are the only thing that shows the behaviour that depends on a sequence. That covers the exact waveform shape over two periods, the width and period values measured from a synchronized pin, watchdog restarts under a steady edge train against expiry once the edges stop, tick gating, and how enables and flag clears interact across timers.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PWM  = 2'd1,
    MODE_CAPT = 2'd2,
    MODE_WDOG = 2'd3
  } gptMode_e;

  // bit 5 runOnce, 4 tickSrc, 3 irqEn, 2 invert, [1:0] mode
  typedef struct packed {
    logic     runOnce;
    logic     tickSrc;
    logic     irqEn;
    logic     invert;
    gptMode_e mode;
  } gptCfg_t;

  localparam int CFG_W = $bits(gptCfg_t);

  typedef struct packed {
    logic cntOne;
    logic cntClr;
    logic cntInc;
    logic perCap;
    logic widCap;
    logic evt;
    logic stop;
  } gptStrb_t;

endpackage

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     start,
  input  gptCfg_t  cfg,
  input  logic     tick,
  input  logic     pinIn,
  input  logic     atEnd,
  output gptStrb_t strb
);

  logic [1:0] syncQ;
  logic       prevLvl;
  logic       armed;
  logic       lvl;
  logic       rise;
  logic       fall;
  logic       adv;

  assign lvl  = syncQ[1] ^ cfg.invert;
  assign rise = lvl & ~prevLvl;
  assign fall = ~lvl & prevLvl;
  assign adv  = cfg.tickSrc ? tick : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
      armed   <= 1'b0;
    end else begin
      syncQ   <= {syncQ[0], pinIn};
      prevLvl <= lvl;
      if (start)
        armed <= 1'b0;
      else if (enable && cfg.mode == MODE_CAPT && rise)
        armed <= 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    if (start) begin
      strb.cntClr = 1'b1;
    end else if (enable) begin
      unique case (cfg.mode)
        MODE_PWM: begin
          if (adv) begin
            if (atEnd) begin
              strb.cntClr = 1'b1;
              strb.evt    = 1'b1;
              strb.stop   = cfg.runOnce;
            end else begin
              strb.cntInc = 1'b1;
            end
          end
        end
        MODE_CAPT: begin
          if (rise) begin
            strb.cntOne = adv;
            strb.cntClr = ~adv;
            if (armed) begin
              strb.perCap = 1'b1;
              strb.evt    = 1'b1;
              strb.stop   = cfg.runOnce;
            end
          end else begin
            strb.widCap = fall & armed;
            strb.cntInc = adv;
          end
        end
        MODE_WDOG: begin
          if (rise) begin
            strb.cntClr = 1'b1;
          end else if (adv) begin
            if (atEnd) begin
              strb.cntClr = 1'b1;
              strb.evt    = 1'b1;
              strb.stop   = cfg.runOnce;
            end else begin
              strb.cntInc = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R6: an edge in watchdog mode never raises an expiry at the same time
  a_r6_edge_beats_expiry: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !start && cfg.mode == MODE_WDOG && rise) |-> !strb.evt);

endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  gptStrb_t         strb,
  input  logic             cntWr,
  input  logic             perWr,
  input  logic             widWr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             pwmMode,
  input  logic             enable,
  input  logic             invert,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] width,
  output logic             atEnd,
  output logic             pinOut,
  output logic             pinOe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      period <= '0;
      width  <= '0;
    end else begin
      if (strb.cntOne)      count <= ONE;
      else if (strb.cntClr) count <= '0;
      else if (cntWr)       count <= wrData;
      else if (strb.cntInc) count <= count + ONE;

      if (strb.perCap)      period <= count;
      else if (perWr)       period <= wrData;

      if (strb.widCap)      width <= count;
      else if (widWr)       width <= wrData;
    end
  end

  assign atEnd  = (count == period - ONE);
  assign pinOe  = pwmMode;
  assign pinOut = invert ^ (enable & pwmMode & (count < width));

  // R5: a captured period equals the count at the capture edge
  a_r5_period_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.perCap |=> period == $past(count));

  // R7: an increment steps the count by exactly one
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntInc && !strb.cntClr && !strb.cntOne && !cntWr) |=> count == $past(count) + ONE);

endmodule

// File: rtl/gpt_timer_bank.sv
module gpt_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = $clog2(4 * (NUM_TIMERS + 1))
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [CNT_W-1:0]      regWrData,
  output logic [CNT_W-1:0]      regRdData,
  input  logic [NUM_TIMERS-1:0] pinIn,
  output logic [NUM_TIMERS-1:0] pinOut,
  output logic [NUM_TIMERS-1:0] pinOe,
  output logic [NUM_TIMERS-1:0] irq
);

  localparam int N = NUM_TIMERS;

  logic             glbWr;
  logic [N-1:0]     setBits, clrBits, flagClr;
  logic [N-1:0]     enR, flagR, startP, evtV, stopV, atEndV;
  gptCfg_t          cfgR  [N];
  gptStrb_t         strbV [N];
  logic [CNT_W-1:0] cntV  [N];
  logic [CNT_W-1:0] perV  [N];
  logic [CNT_W-1:0] widV  [N];

  assign glbWr   = regWr && (regAddr == '0);
  assign setBits = glbWr ? regWrData[N-1:0]     : '0;
  assign clrBits = glbWr ? regWrData[2*N-1:N]   : '0;
  assign flagClr = glbWr ? regWrData[3*N-1:2*N] : '0;
  assign startP  = setBits & ~clrBits & ~enR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enR   <= '0;
      flagR <= '0;
    end else begin
      enR   <= (enR | setBits) & ~clrBits & ~stopV;
      flagR <= (flagR & ~flagClr) | evtV;
    end
  end

  for (genvar t = 0; t < N; t++) begin : g_tmr
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * (t + 1));

    always_ff @(posedge clk) begin
      if (!rstN)
        cfgR[t] <= '0;
      else if (regWr && regAddr == BASE)
        cfgR[t] <= gptCfg_t'(regWrData[CFG_W-1:0]);
    end

    gpt_ctrl u_ctrl (
      .clk    (clk),
      .rstN   (rstN),
      .enable (enR[t]),
      .start  (startP[t]),
      .cfg    (cfgR[t]),
      .tick   (tick),
      .pinIn  (pinIn[t]),
      .atEnd  (atEndV[t]),
      .strb   (strbV[t])
    );

    gpt_datapath #(.CNT_W(CNT_W)) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strbV[t]),
      .cntWr   (regWr && regAddr == BASE + ADDR_W'(1)),
      .perWr   (regWr && regAddr == BASE + ADDR_W'(2)),
      .widWr   (regWr && regAddr == BASE + ADDR_W'(3)),
      .wrData  (regWrData),
      .pwmMode (cfgR[t].mode == MODE_PWM),
      .enable  (enR[t]),
      .invert  (cfgR[t].invert),
      .count   (cntV[t]),
      .period  (perV[t]),
      .width   (widV[t]),
      .atEnd   (atEndV[t]),
      .pinOut  (pinOut[t]),
      .pinOe   (pinOe[t])
    );

    assign evtV[t]  = strbV[t].evt;
    assign stopV[t] = strbV[t].stop;
    assign irq[t]   = flagR[t] & cfgR[t].irqEn;

    // R8: a run-once event leaves the timer disabled
    a_r8_run_once_stop: assert property (@(posedge clk) disable iff (!rstN)
      (evtV[t] && cfgR[t].runOnce) |=> !enR[t]);

    // R11: a stopped timer raises no event
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !enR[t] |-> !evtV[t]);

    // R9: a flag only rises after an event
    a_r9_flag_source: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagR[t]) |-> $past(evtV[t]));
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == '0) begin
      regRdData[N-1:0]     = enR;
      regRdData[3*N-1:2*N] = flagR;
    end
    for (int t = 0; t < N; t++) begin
      if (regAddr == ADDR_W'(4 * (t + 1)))     regRdData = CNT_W'(cfgR[t]);
      if (regAddr == ADDR_W'(4 * (t + 1) + 1)) regRdData = cntV[t];
      if (regAddr == ADDR_W'(4 * (t + 1) + 2)) regRdData = perV[t];
      if (regAddr == ADDR_W'(4 * (t + 1) + 3)) regRdData = widV[t];
    end
  end

endmodule

// File: tb/gpt_timer_bank_tb.sv
module gpt_timer_bank_tb;

  localparam int N      = 3;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic              regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [CNT_W-1:0]  regWrData = '0;
  logic [CNT_W-1:0]  regRdData;
  logic [N-1:0]      pinIn = '0;
  logic [N-1:0]      pinOut, pinOe, irq;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpt_timer_bank #(.NUM_TIMERS(N), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // kind: 0 register read, 1 pin level of timer addr, 2 irq vector, 3 oe vector
  typedef struct {
    int          kind;
    int          addr;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t expQ[$];

  task automatic chk(input int kind, input int addr, input logic [31:0] mask,
                     input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    if (kind == 0) regAddr = ADDR_W'(addr);
    it.kind = kind; it.addr = addr; it.mask = mask; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: pops expectations and compares them with the outputs
  always @(negedge clk) begin
    #2;
    while (expQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = expQ.pop_front();
      case (it.kind)
        0: act = regRdData;
        1: act = {31'd0, pinOut[it.addr]};
        2: act = {29'd0, irq};
        default: act = {29'd0, pinOe};
      endcase
      nTests++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        nFail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = ADDR_W'(addr); regWrData = data; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int addr, output logic [31:0] v);
    @(negedge clk);
    regAddr = ADDR_W'(addr);
    #1 v = regRdData;
  endtask

  task automatic finish_run();
    idle(3);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] held;
    idle(3);
    rstN = 1'b1;

    // R1 reset state
    chk(0, 0, 32'hFFFF_FFFF, 0, "R1 status");
    chk(0, 4, 32'hFFFF_FFFF, 0, "R1 cfg0");
    chk(0, 5, 32'hFFFF_FFFF, 0, "R1 count0");
    chk(0, 14, 32'hFFFF_FFFF, 0, "R1 period2");
    chk(3, 0, 32'h7, 0, "R1 pinOe");
    chk(2, 0, 32'h7, 0, "R1 irq");

    // R12 register access, R2 waveform on timer 0
    wr(6, 5); wr(7, 2); wr(4, 1);
    chk(0, 6, 32'hFFFF_FFFF, 5, "R12 period0 readback");
    chk(0, 7, 32'hFFFF_FFFF, 2, "R12 width0 readback");
    chk(3, 0, 32'h7, 1, "R2 pinOe in waveform mode");
    wr(0, 1);
    for (int k = 0; k < 10; k++)
      chk(1, 0, 1, (((k + 1) % 5) < 2) ? 1 : 0, "R2 waveform pin");
    chk(0, 0, 32'h40, 32'h40, "R3 flag after wrap");
    chk(2, 0, 32'h1, 0, "R9 irq gated off");
    wr(4, 9);
    chk(2, 0, 32'h1, 1, "R9 irq enabled");

    // R11 hold while disabled, R10 disable
    wr(0, 1 << 3);
    chk(0, 0, 32'h1, 0, "R10 disable bit");
    rd(5, held);
    idle(7);
    chk(0, 5, 32'hFFFF_FFFF, held, "R11 count held");
    wr(0, 1 << 6);
    chk(0, 0, 32'h40, 0, "R9 flag cleared");
    chk(2, 0, 32'h1, 0, "R9 irq low after clear");

    // R4 polarity
    wr(4, 5);
    chk(1, 0, 1, 1, "R4 inactive level high when stopped");
    wr(0, 1);
    chk(1, 0, 1, 0, "R4 active low");
    chk(1, 0, 1, 1, "R4 inactive after width");
    wr(0, 1 << 3);

    // R5 capture on timer 1
    wr(8, 2);
    wr(0, 2);
    chk(0, 0, 32'h7, 32'h2, "R10 only timer 1 enabled");
    idle(5);
    for (int i = 0; i < 3; i++) begin
      pinIn[1] = 1'b1; idle(3);
      pinIn[1] = 1'b0; idle(4);
    end
    idle(6);
    chk(0, 11, 32'hFFFF_FFFF, 3, "R5 width capture");
    chk(0, 10, 32'hFFFF_FFFF, 7, "R5 period capture");
    chk(0, 0, 32'h80, 32'h80, "R5 capture flag");
    wr(0, 1 << 4);

    // R7 tick source on timer 2 (watchdog)
    wr(14, 3); wr(12, 32'h13);
    wr(0, 4);
    idle(20);
    chk(0, 13, 32'hFFFF_FFFF, 0, "R7 no advance without tick");
    chk(0, 0, 32'h100, 0, "R7 no flag without tick");
    tick = 1'b1;
    idle(6);
    tick = 1'b0;
    chk(0, 0, 32'h100, 32'h100, "R7 expiry with tick");
    wr(0, (1 << 5) | (1 << 8));

    // R6 watchdog edge restarts then expiry
    wr(14, 10); wr(12, 3);
    wr(0, 4);
    for (int i = 0; i < 6; i++) begin
      pinIn[2] = 1'b1; idle(3);
      pinIn[2] = 1'b0; idle(3);
    end
    chk(0, 0, 32'h100, 0, "R6 edges hold off expiry");
    idle(15);
    chk(0, 0, 32'h100, 32'h100, "R6 expiry after edges stop");
    wr(0, (1 << 5) | (1 << 8));

    // R8 run once
    wr(14, 4); wr(12, 32'h23);
    wr(0, 4);
    idle(10);
    chk(0, 0, 32'h104, 32'h100, "R8 run once disables");

    finished = 1;
    finish_run();
  end

endmodule